// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block sits between a simple request port and one bank of a synchronous DRAM. It turns row/column read and write requests into the DRAM's command stream on chip select, row strobe, column strobe, write enable and the multiplexed address lines. It drives every command from a register. It enforces all command-to-command spacing with clock-count timers that it builds from parameters. The data path is not part of this block.

After reset the block brings the memory up before it accepts any request. It closes all banks, issues a parameterised number of refreshes, and then writes the mode word that carries read latency, burst length and burst type. After that it keeps at most one row open. A request to the open row goes straight to a column command. A request to any other row first closes the open row and then opens the new one. A free-running deadline counter raises a refresh demand once per period. The demand beats user requests, and the block closes any open row before it refreshes.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as: idle 0111, open row 0011, read 0101, write 0100, close 0010, burst halt 0110, refresh 0001, mode write 0000. The block drives only these codes, and cs_n is always low.
- R2: During reset and until start-up ends, the command is idle (0111), init_done is 0 and req_ready is 0. The first non-idle commands after reset are, in order: a close with sd_addr[10]=1, INIT_REFRESHES refreshes, and the mode write. init_done is 1 from the cycle the mode write appears on the pins.
- R3: During the mode write, sd_addr[2:0] holds log2(BURST_LEN), sd_addr[3] holds BURST_INTERLEAVE, sd_addr[6:4] holds CAS_LAT, and all higher bits are 0.
- R4: A read or write comes at least T_RCD cycles after the open-row command.
- R5: An open-row or refresh command comes at least T_RP cycles after a close.
- R6: A close comes at least T_RAS cycles after the open-row command.
- R7: Open-row and refresh commands are each at least T_RC cycles after the previous open-row or refresh command.
- R8: A close comes at least BURST_LEN-1+T_WR cycles after a write. An open-row command comes at least BURST_LEN-1+T_DAL cycles after a write.
- R9: No command other than idle comes within T_MRD cycles after the mode write.
- R10: A refresh is never issued while a row is open. After start-up, consecutive refreshes are REF_PERIOD cycles apart, within the slack T_RAS+BURST_LEN-1+T_DAL+T_RP+T_RC+2.
- R11: A request to the open row gets a column command with no open-row command in between. A request to another row, or the first request after a refresh, causes exactly one open-row command with the row on sd_addr. Any preceding close after start-up has sd_addr[10]=0.
- R12: req_ready may be high only after start-up. A request accepted (req_valid and req_ready high at a clock edge) appears on the pins in the very next cycle as a read (req_write=0) or write (req_write=1). The column is on sd_addr and sd_addr[10] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_ready | output | 1 | Request accepted at this edge when req_valid is high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Row, column, mode word or all-bank flag (bit 10) |
| init_done | output | 1 | Start-up sequence finished |

## Verification
An accepted request must show up as a column command exactly one cycle after the accepting edge. The scoreboard stamps each queued item with that cycle and compares it at the next falling edge. Every spacing rule is measured on the pins in whole cycles since the command it depends on, so the first legal cycle is the timer value itself and never one less. A refresh falls due once per period but may be delayed by closing an open row. The refresh spacing is therefore checked against a window around the period and not against an exact cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      C_MRS = 4'b0000,
      C_REF = 4'b0001,
      C_PRE = 4'b0010,
      C_ACT = 4'b0011,
      C_WR  = 4'b0100,
      C_RD  = 4'b0101,
      C_BST = 4'b0110,
      C_NOP = 4'b0111
   } sdram_cmd_e;

   function automatic logic [2:0] burst_code(input int bl);
      case (bl)
         2:       return 3'd1;
         4:       return 3'd2;
         8:       return 3'd3;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
   parameter int GAP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic clear
);
   generate
      if (GAP <= 1) begin : g_none
         logic unused_pins;
         assign unused_pins = ^{clk, rst_n, fire};
         assign clear = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(GAP);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (fire)
               cnt <= CW'(GAP - 1);
            else if (cnt != '0)
               cnt <= cnt - 1'b1;
         end
         assign clear = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/seq_refresh_due.sv
module seq_refresh_due #(
   parameter int PERIOD = 976
) (
   input  logic clk,
   input  logic rst_n,
   input  logic served,
   output logic due
);
   localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

   logic [CW-1:0] cnt;
   logic          tick;

   assign tick = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= CW'(PERIOD - 1);
         due <= 1'b0;
      end else begin
         cnt <= tick ? CW'(PERIOD - 1) : cnt - 1'b1;
         if (tick)
            due <= 1'b1;
         else if (served)
            due <= 1'b0;
      end
   end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdram_seq_pkg::*;
#(
   parameter int ROW_W            = 13,
   parameter int COL_W            = 10,
   parameter int ADDR_W           = 13,
   parameter int T_RCD            = 3,
   parameter int T_RP             = 3,
   parameter int T_RAS            = 6,
   parameter int T_RC             = 9,
   parameter int T_WR             = 2,
   parameter int T_DAL            = 5,
   parameter int T_MRD            = 2,
   parameter int BURST_LEN        = 1,
   parameter int BURST_INTERLEAVE = 0,
   parameter int CAS_LAT          = 3,
   parameter int INIT_REFRESHES   = 2,
   parameter int REF_PERIOD       = 976
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              req_ready,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              init_done
);
   localparam int AP_BIT    = 10;
   localparam int WR_TO_PRE = BURST_LEN - 1 + T_WR;
   localparam int WR_TO_ACT = BURST_LEN - 1 + T_DAL;
   localparam int RD_TO_PRE = BURST_LEN;
   localparam int COL_GAP   = BURST_LEN;
   localparam int PH_MRS    = INIT_REFRESHES + 1;
   localparam int PH_DONE   = INIT_REFRESHES + 2;
   localparam int PH_W      = $clog2(PH_DONE + 1);
   localparam logic [ADDR_W-1:0] MODE_WORD =
      ADDR_W'({3'(CAS_LAT), 1'(BURST_INTERLEAVE), burst_code(BURST_LEN)});

   // timer slots
   localparam int TI_RCD = 0, TI_RAS = 1, TI_RC = 2, TI_RP = 3, TI_WPRE = 4,
                  TI_DAL = 5, TI_RPRE = 6, TI_CCD = 7, TI_MRD = 8, NT = 9;

   function automatic int gap_of(input int idx);
      case (idx)
         TI_RCD:  return T_RCD;
         TI_RAS:  return T_RAS;
         TI_RC:   return T_RC;
         TI_RP:   return T_RP;
         TI_WPRE: return WR_TO_PRE;
         TI_DAL:  return WR_TO_ACT;
         TI_RPRE: return RD_TO_PRE;
         TI_CCD:  return COL_GAP;
         default: return T_MRD;
      endcase
   endfunction

   // elaboration-time parameter checks
   if (ADDR_W <= AP_BIT || ADDR_W < ROW_W || COL_W > AP_BIT) begin : g_bad_width
      $error("sdram_cmd_seq: address widths do not fit");
   end
   if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cl
      $error("sdram_cmd_seq: CAS_LAT must be 2 or 3");
   end
   if (BURST_LEN != 1 && BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
      $error("sdram_cmd_seq: BURST_LEN must be 1, 2, 4 or 8");
   end
   if (REF_PERIOD < 2 || T_RC > 255 || T_RAS > 255 || WR_TO_ACT > 255) begin : g_bad_time
      $error("sdram_cmd_seq: timing parameter out of range");
   end

   logic [PH_W-1:0]  phase;
   logic             in_service;
   logic             open_q;
   logic [ROW_W-1:0] open_row_q;
   logic             row_hit;
   logic             ref_due;
   logic             served;
   logic             adv;
   logic             open_set, open_clr;
   sdram_cmd_e       nxt_cmd, cmd_q;
   logic [ADDR_W-1:0] nxt_addr, addr_q;
   logic [NT-1:0]    t_fire, t_clear;
   logic             rcd_ok, ras_ok, rc_ok, rp_ok, pre_ok, dal_ok, col_ok, mrd_ok;

   genvar gi;
   generate
      for (gi = 0; gi < NT; gi++) begin : g_tmr
         seq_gap_timer #(.GAP(gap_of(gi))) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (t_fire[gi]),
            .clear (t_clear[gi])
         );
      end
   endgenerate

   seq_refresh_due #(.PERIOD(REF_PERIOD)) u_ref (
      .clk    (clk),
      .rst_n  (rst_n),
      .served (served),
      .due    (ref_due)
   );

   assign rcd_ok = t_clear[TI_RCD];
   assign ras_ok = t_clear[TI_RAS];
   assign rc_ok  = t_clear[TI_RC];
   assign rp_ok  = t_clear[TI_RP];
   assign dal_ok = t_clear[TI_DAL];
   assign mrd_ok = t_clear[TI_MRD];
   assign pre_ok = ras_ok & t_clear[TI_WPRE] & t_clear[TI_RPRE];
   assign col_ok = rcd_ok & t_clear[TI_CCD];

   assign in_service = (phase == PH_W'(PH_DONE));
   assign row_hit    = open_q && (open_row_q == req_row);
   assign req_ready  = in_service && mrd_ok && !ref_due && row_hit && col_ok;

   always_comb begin
      nxt_cmd  = C_NOP;
      nxt_addr = '0;
      adv      = 1'b0;
      served   = 1'b0;
      open_set = 1'b0;
      open_clr = 1'b0;
      if (!in_service) begin
         if (phase == '0) begin
            if (mrd_ok) begin
               nxt_cmd          = C_PRE;
               nxt_addr[AP_BIT] = 1'b1;
               adv              = 1'b1;
            end
         end else if (phase < PH_W'(PH_MRS)) begin
            if (rp_ok && rc_ok) begin
               nxt_cmd = C_REF;
               adv     = 1'b1;
            end
         end else if (rc_ok) begin
            nxt_cmd  = C_MRS;
            nxt_addr = MODE_WORD;
            adv      = 1'b1;
         end
      end else if (mrd_ok) begin
         if (ref_due) begin
            if (open_q) begin
               if (pre_ok) begin
                  nxt_cmd  = C_PRE;
                  open_clr = 1'b1;
               end
            end else if (rp_ok && rc_ok) begin
               nxt_cmd = C_REF;
               served  = 1'b1;
            end
         end else if (req_valid) begin
            if (row_hit) begin
               if (req_ready) begin
                  nxt_cmd  = req_write ? C_WR : C_RD;
                  nxt_addr = ADDR_W'(req_col);
               end
            end else if (open_q) begin
               if (pre_ok) begin
                  nxt_cmd  = C_PRE;
                  open_clr = 1'b1;
               end
            end else if (rp_ok && rc_ok && dal_ok) begin
               nxt_cmd  = C_ACT;
               nxt_addr = ADDR_W'(req_row);
               open_set = 1'b1;
            end
         end
      end
   end

   always_comb begin
      t_fire          = '0;
      t_fire[TI_RCD]  = (nxt_cmd == C_ACT);
      t_fire[TI_RAS]  = (nxt_cmd == C_ACT);
      t_fire[TI_RC]   = (nxt_cmd == C_ACT) || (nxt_cmd == C_REF);
      t_fire[TI_RP]   = (nxt_cmd == C_PRE);
      t_fire[TI_WPRE] = (nxt_cmd == C_WR);
      t_fire[TI_DAL]  = (nxt_cmd == C_WR);
      t_fire[TI_RPRE] = (nxt_cmd == C_RD);
      t_fire[TI_CCD]  = (nxt_cmd == C_RD) || (nxt_cmd == C_WR);
      t_fire[TI_MRD]  = (nxt_cmd == C_MRS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= '0;
         open_q     <= 1'b0;
         open_row_q <= '0;
         cmd_q      <= C_NOP;
         addr_q     <= '0;
      end else begin
         if (adv)
            phase <= phase + 1'b1;
         if (open_set) begin
            open_q     <= 1'b1;
            open_row_q <= req_row;
         end else if (open_clr) begin
            open_q <= 1'b0;
         end
         cmd_q  <= nxt_cmd;
         addr_q <= nxt_addr;
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_addr   = addr_q;
   assign init_done = in_service;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
   parameter int ROW_W            = 13,
   parameter int COL_W            = 10,
   parameter int ADDR_W           = 13,
   parameter int T_RCD            = 3,
   parameter int T_RP             = 3,
   parameter int T_RAS            = 6,
   parameter int T_RC             = 9,
   parameter int T_WR             = 2,
   parameter int T_DAL            = 5,
   parameter int T_MRD            = 2,
   parameter int BURST_LEN        = 1,
   parameter int BURST_INTERLEAVE = 0,
   parameter int CAS_LAT          = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ROW_W-1:0]  req_row,
   input logic [COL_W-1:0]  req_col,
   input logic              req_ready,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [ADDR_W-1:0] sd_addr,
   input logic              init_done
);
   localparam int WR_TO_PRE = BURST_LEN - 1 + T_WR;
   localparam int WR_TO_ACT = BURST_LEN - 1 + T_DAL;
   localparam logic [ADDR_W-1:0] MODE_EXP =
      ADDR_W'((CAS_LAT << 4) | (BURST_INTERLEAVE << 3) | $clog2(BURST_LEN));

   logic [3:0] code;
   logic is_act, is_pre, is_ref, is_mrs, is_wr, is_col, is_nop;
   logic [7:0] s_act, s_pre, s_rc, s_wr, s_mrs;
   logic       row_open_c;
   logic       unused_req;

   assign unused_req = ^{req_write, req_row, req_col};
   assign code   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   assign is_nop = (code == 4'b0111);
   assign is_act = (code == 4'b0011);
   assign is_pre = (code == 4'b0010);
   assign is_ref = (code == 4'b0001);
   assign is_mrs = (code == 4'b0000);
   assign is_wr  = (code == 4'b0100);
   assign is_col = (code == 4'b0100) || (code == 4'b0101);

   function automatic logic [7:0] bump(input logic hit, input logic [7:0] v);
      if (hit)          return 8'd1;
      else if (v != '1) return v + 8'd1;
      else              return v;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_act      <= '1;
         s_pre      <= '1;
         s_rc       <= '1;
         s_wr       <= '1;
         s_mrs      <= '1;
         row_open_c <= 1'b0;
      end else begin
         s_act <= bump(is_act, s_act);
         s_pre <= bump(is_pre, s_pre);
         s_rc  <= bump(is_act || is_ref, s_rc);
         s_wr  <= bump(is_wr, s_wr);
         s_mrs <= bump(is_mrs, s_mrs);
         if (is_act)
            row_open_c <= 1'b1;
         else if (is_pre)
            row_open_c <= 1'b0;
      end
   end

   p_cs_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !is_nop |-> !sd_cs_n);
   p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> init_done);
   p_mode_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (sd_addr == MODE_EXP));
   p_rcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (s_act >= 8'(T_RCD)));
   p_rp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act || is_ref) |-> (s_pre >= 8'(T_RP)));
   p_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (s_act >= 8'(T_RAS)));
   p_rc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act || is_ref) |-> (s_rc >= 8'(T_RC)));
   p_wr_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (s_wr >= 8'(WR_TO_PRE)));
   p_wr_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> (s_wr >= 8'(WR_TO_ACT)));
   p_mrd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !is_nop |-> (s_mrs >= 8'(T_MRD)));
   p_ref_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> !row_open_c);
   p_accept_col_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> is_col);
   p_col_a10_r12: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> !sd_addr[10]);

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
   .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
   .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
   .T_WR(T_WR), .T_DAL(T_DAL), .T_MRD(T_MRD),
   .BURST_LEN(BURST_LEN), .BURST_INTERLEAVE(BURST_INTERLEAVE), .CAS_LAT(CAS_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
   .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
   .sd_addr(sd_addr), .init_done(init_done)
);

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
   localparam int CLK_PERIOD     = 10;
   localparam int ROW_W          = 13;
   localparam int COL_W          = 10;
   localparam int ADDR_W         = 13;
   localparam int T_RCD          = 3;
   localparam int T_RP           = 3;
   localparam int T_RAS          = 6;
   localparam int T_RC           = 9;
   localparam int T_WR           = 2;
   localparam int T_DAL          = 5;
   localparam int T_MRD          = 2;
   localparam int BURST_LEN      = 1;
   localparam int INTERLEAVE     = 0;
   localparam int CAS_LAT        = 3;
   localparam int INIT_REFRESHES = 2;
   localparam int REF_PERIOD     = 150;
   localparam int WR_TO_PRE      = BURST_LEN - 1 + T_WR;
   localparam int WR_TO_ACT      = BURST_LEN - 1 + T_DAL;
   localparam int SLACK          = T_RAS + WR_TO_ACT + T_RP + T_RC + 2;
   localparam int K_NOP = 7, K_ACT = 3, K_RD = 5, K_WR = 4, K_PRE = 2, K_REF = 1, K_MRS = 0;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_write;
   logic [ROW_W-1:0]  req_row;
   logic [COL_W-1:0]  req_col;
   logic              req_ready;
   logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [ADDR_W-1:0] sd_addr;
   logic              init_done;

   sdram_cmd_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_WR(T_WR), .T_DAL(T_DAL), .T_MRD(T_MRD),
      .BURST_LEN(BURST_LEN), .BURST_INTERLEAVE(INTERLEAVE), .CAS_LAT(CAS_LAT),
      .INIT_REFRESHES(INIT_REFRESHES), .REF_PERIOD(REF_PERIOD)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_addr(sd_addr), .init_done(init_done)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      bit wr;
      int row;
      int col;
      int cyc;
   } item_t;
   item_t q[$];

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor state
   int  last_act = -1000, last_pre = -1000, last_rc = -1000, last_wr = -1000;
   int  last_mrs = -1000, last_col = -1000, last_ref_post = -1, init_cyc = -1;
   int  nn_idx = 0, n_ref_post = 0;
   bit  open_b = 0;
   int  open_row = -1, last_col_row = -1, acts_since_col = 0, refs_since_col = 0;
   int  code;
   item_t it;

   always @(negedge clk) begin
      if (rst_n) begin
         code = int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
         if (code != K_NOP) begin
            check(!sd_cs_n && (code == K_ACT || code == K_RD || code == K_WR ||
                  code == K_PRE || code == K_REF || code == K_MRS),
                  "R1", "command code", code, K_ACT);
            if (last_mrs >= 0)
               check(cyc - last_mrs >= T_MRD, "R9", "gap after mode write", cyc - last_mrs, T_MRD);
            if (nn_idx == 0) begin
               check(code == K_PRE, "R2", "first start-up command", code, K_PRE);
               check(sd_addr[10] == 1'b1, "R2", "all-bank flag", int'(sd_addr[10]), 1);
            end else if (nn_idx <= INIT_REFRESHES) begin
               check(code == K_REF, "R2", "start-up refresh", code, K_REF);
            end else if (nn_idx == INIT_REFRESHES + 1) begin
               check(code == K_MRS, "R2", "start-up mode write", code, K_MRS);
               check(init_done == 1'b1, "R2", "init_done with mode write", int'(init_done), 1);
               check(int'(sd_addr) == ((CAS_LAT << 4) | (INTERLEAVE << 3) | $clog2(BURST_LEN)),
                     "R3", "mode word", int'(sd_addr),
                     (CAS_LAT << 4) | (INTERLEAVE << 3) | $clog2(BURST_LEN));
               init_cyc = cyc;
            end
            case (code)
               K_ACT: begin
                  check(cyc - last_pre >= T_RP, "R5", "close to open gap", cyc - last_pre, T_RP);
                  check(cyc - last_rc >= T_RC, "R7", "row cycle before open", cyc - last_rc, T_RC);
                  check(cyc - last_wr >= WR_TO_ACT, "R8", "write to open gap", cyc - last_wr, WR_TO_ACT);
                  last_act = cyc; last_rc = cyc;
                  open_b = 1; open_row = int'(sd_addr);
                  acts_since_col++;
               end
               K_PRE: begin
                  check(cyc - last_act >= T_RAS, "R6", "open to close gap", cyc - last_act, T_RAS);
                  check(cyc - last_wr >= WR_TO_PRE, "R8", "write to close gap", cyc - last_wr, WR_TO_PRE);
                  if (nn_idx > INIT_REFRESHES + 1)
                     check(sd_addr[10] == 1'b0, "R11", "single-bank close flag", int'(sd_addr[10]), 0);
                  last_pre = cyc; open_b = 0;
               end
               K_REF: begin
                  check(cyc - last_pre >= T_RP, "R5", "close to refresh gap", cyc - last_pre, T_RP);
                  check(cyc - last_rc >= T_RC, "R7", "row cycle before refresh", cyc - last_rc, T_RC);
                  check(!open_b, "R10", "row closed at refresh", int'(open_b), 0);
                  if (nn_idx > INIT_REFRESHES + 1) begin
                     if (last_ref_post >= 0) begin
                        check(cyc - last_ref_post <= REF_PERIOD + SLACK, "R10", "refresh spacing max",
                              cyc - last_ref_post, REF_PERIOD + SLACK);
                        check(cyc - last_ref_post >= REF_PERIOD - SLACK, "R10", "refresh spacing min",
                              cyc - last_ref_post, REF_PERIOD - SLACK);
                     end
                     last_ref_post = cyc;
                     n_ref_post++;
                  end
                  last_rc = cyc;
                  refs_since_col++;
               end
               K_MRS: last_mrs = cyc;
               K_RD, K_WR: begin
                  check(cyc - last_act >= T_RCD, "R4", "open to column gap", cyc - last_act, T_RCD);
                  check(cyc - last_col >= BURST_LEN, "R4", "column spacing", cyc - last_col, BURST_LEN);
                  check(q.size() > 0, "R12", "column command with no request", q.size(), 1);
                  if (q.size() > 0) begin
                     it = q.pop_front();
                     check(it.cyc == cyc, "R12", "column cycle", cyc, it.cyc);
                     check((code == K_WR) == it.wr, "R12", "read/write kind", code, it.wr ? K_WR : K_RD);
                     check(int'(sd_addr) == it.col, "R12", "column address", int'(sd_addr), it.col);
                     check(sd_addr[10] == 1'b0, "R12", "column flag bit", int'(sd_addr[10]), 0);
                     check(open_b && open_row == it.row, "R11", "open row", open_row, it.row);
                     if (it.row == last_col_row && refs_since_col == 0)
                        check(acts_since_col == 0, "R11", "row hit opens", acts_since_col, 0);
                     else
                        check(acts_since_col == 1, "R11", "row miss opens", acts_since_col, 1);
                     last_col_row = it.row;
                  end
                  if (code == K_WR) last_wr = cyc;
                  last_col = cyc;
                  acts_since_col = 0;
                  refs_since_col = 0;
               end
               default: ;
            endcase
            nn_idx++;
         end
      end
   end

   task automatic send(input bit w, input int row, input int col);
      item_t ni;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = w;
      req_row   = ROW_W'(row);
      req_col   = COL_W'(col);
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      ni.wr = w; ni.row = row; ni.col = col; ni.cyc = cyc + 1;
      q.push_back(ni);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      bit early;
      int end_cyc;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_row = '0; req_col = '0;
      repeat (3) @(negedge clk);
      // R2: reset state
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R2", "reset command",
            int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), K_NOP);
      check(init_done == 1'b0, "R2", "reset init_done", int'(init_done), 0);
      check(req_ready == 1'b0, "R2", "reset ready", int'(req_ready), 0);
      rst_n = 1'b1;
      req_valid = 1'b1; req_row = 1; req_col = 1;
      early = 0;
      #1;
      while (!init_done) begin
         if (req_ready) early = 1;
         @(negedge clk);
         #1;
      end
      req_valid = 1'b0;
      check(!early, "R2", "ready during start-up", int'(early), 0);

      // directed patterns: hit, miss, column extremes
      send(1, 5, 3);
      send(0, 5, 4);
      send(1, 9, 1);
      send(0, 9, 1023);
      send(0, 0, 0);
      send(1, 0, 7);
      send(1, 0, 8);
      // mixed traffic across refresh periods
      for (int i = 0; i < 60; i++)
         send(i % 3 == 0, (i % 5 == 0) ? 20 + (i % 4) : 20, (i * 37) % 1024);
      repeat (20) @(negedge clk);
      // idle window with row left open: refreshes must still come
      repeat (4 * REF_PERIOD) @(negedge clk);
      check(q.size() == 0, "R12", "requests left unissued", q.size(), 0);
      end_cyc = cyc;
      check(n_ref_post >= (end_cyc - init_cyc) / REF_PERIOD - 1, "R10", "refresh count",
            n_ref_post, (end_cyc - init_cyc) / REF_PERIOD - 1);
      finish_run();
   end

endmodule